// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block connects a clocked system to an external static RAM that has no clock. The RAM holds 1,048,576 words of one bit each. It has a 20-bit address, a data-in line and a separate data-out line, an active-low chip select and an active-low write enable. On the user side the block accepts one request at a time. A request carries a write flag, an address and a write bit. The block answers with a one-cycle done pulse and, after a read, a registered read bit.

Each access runs through a fixed sequence: idle, setup, then a read wait or a write pulse, then recovery, then idle. Every phase length is a whole number of clock cycles. Each count is worked out at elaboration from the clock period and from the memory's minimum times: access time, write-enable width, address and select to end of write, data setup and write recovery. Each count is rounded up so that every minimum is met.

The memory only writes while chip select and write enable are both low. The write-enable pulse therefore always sits inside the chip-select window. Write enable falls one cycle after chip select, and both rise together. Because chip select is already low when write enable falls, write enable times the write.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `ready`=1, `mem_cs_n`=1, `mem_we_n`=1, `done`=0 and `rdata`=0.
- R2: `ready` is high only in the idle state, and there both strobes are high. A request is accepted only on a clock edge where `req` and `ready` are both high. `addr`, `wr` and `wdata` are latched on that edge, so changes to them, or a held `req`, have no effect until `ready` returns.
- R3: A read (`wr`=0) holds `mem_cs_n`=0 and `mem_we_n`=1 for 1+ACC cycles after acceptance: one setup cycle, then ACC wait cycles. `mem_dout` is captured into `rdata` on the last wait cycle.
- R4: A write (`wr`=1) holds `mem_cs_n`=0 with `mem_we_n`=1 for one setup cycle. It then holds both strobes low for exactly WP cycles. Both strobes rise on the same edge.
- R5: `mem_addr` and `mem_din` stay constant from the cycle chip select falls to the end of recovery.
- R6: With clock period P: ACC = max(1, ceil(t_acc/P)); WP = max(1, ceil(t_wp/P), ceil(t_aw/P)−1, ceil(t_dw/P)−1); REC = max(1, ceil(t_wr/P), ceil(t_rc/P)−1−min(ACC,WP)). The defaults are t_acc=20 ns, t_wp=15 ns, t_aw=17 ns, t_dw=12 ns, t_wr=2 ns and t_rc=20 ns.
- R7: After the read wait or the write pulse, the block spends REC recovery cycles with both strobes high. It then returns to idle with `done`=1 for exactly one cycle. `rdata` keeps its value until the next read completes; writes leave it unchanged.
- R8: `mem_we_n` is never low while `mem_cs_n` is high.
- R9: A bit written to a location is returned by a later read of that location. Unwritten locations seen through the memory read 0, including addresses 0 and 2^20−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Access request, accepted when `ready` is high |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address |
| wdata | input | 1 | Bit to write |
| ready | output | 1 | Idle and able to accept a request |
| done | output | 1 | One-cycle pulse at the end of an access |
| rdata | output | 1 | Last bit read |
| mem_addr | output | ADDR_W | Address to the memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_din | output | 1 | Data into the memory |
| mem_dout | input | 1 | Data out of the memory |

## Verification
The assertions assume that `mem_dout` is valid by the sampling edge and that the user side follows the req/ready rule. They do not depend on the user holding `addr` or `wr` steady while the block is busy. The bench's memory model supplies a wrong bit until chip select has been low, with write enable high, for more than ACC cycles. It commits a write only when the two strobes stop overlapping. The stimulus mixes back-to-back reads and writes at both ends of the address range. It also holds `req` high with scrambled `addr`, `wr` and `wdata` while the block is busy, so that the latching rule is exercised.

// File: rtl/srac_pkg.sv
package srac_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_RDWAIT,
      ST_WPULSE,
      ST_RECOVER
   } srac_state_t;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int min2(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

endpackage

// File: rtl/srac_timer.sv
module srac_timer #(
   parameter int CW = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expired
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/srac_rd_latch.sv
module srac_rd_latch (
   input  logic clk,
   input  logic rst,
   input  logic cap,
   input  logic d,
   output logic q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= 1'b0;
      end else if (cap) begin
         q <= d;
      end
   end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import srac_pkg::*;
#(
   parameter int ADDR_W   = 20,
   parameter int CLK_PS   = 10000,
   parameter int T_ACC_PS = 20000,
   parameter int T_WP_PS  = 15000,
   parameter int T_AW_PS  = 17000,
   parameter int T_DW_PS  = 12000,
   parameter int T_WR_PS  = 2000,
   parameter int T_RC_PS  = 20000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wdata,
   output logic              ready,
   output logic              done,
   output logic              rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs_n,
   output logic              mem_we_n,
   output logic              mem_din,
   input  logic              mem_dout
);

   // R6: phase lengths in whole cycles, each rounded up
   localparam int ACC_CYC = max2(1, ceil_div(T_ACC_PS, CLK_PS));
   localparam int WP_CYC  = max2(max2(1, ceil_div(T_WP_PS, CLK_PS)),
                                 max2(ceil_div(T_AW_PS, CLK_PS) - 1,
                                      ceil_div(T_DW_PS, CLK_PS) - 1));
   localparam int REC_CYC = max2(max2(1, ceil_div(T_WR_PS, CLK_PS)),
                                 ceil_div(T_RC_PS, CLK_PS) - 1 - min2(ACC_CYC, WP_CYC));
   localparam int CNT_MAX = max2(ACC_CYC, max2(WP_CYC, REC_CYC));
   localparam int CW      = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;

   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must be at least 1");
      end
      if (CLK_PS < 1) begin : g_bad_clk
         $error("CLK_PS must be positive");
      end
   endgenerate

   srac_state_t       st_q, st_nxt;
   logic              t_load, t_exp;
   logic [CW-1:0]     t_val;
   logic [ADDR_W-1:0] addr_q;
   logic              din_q, wr_q;
   logic              rd_cap;

   always_comb begin
      st_nxt = st_q;
      t_load = 1'b0;
      t_val  = '0;
      unique case (st_q)
         ST_IDLE: begin
            if (req) st_nxt = ST_SETUP;
         end
         ST_SETUP: begin
            t_load = 1'b1;
            if (wr_q) begin
               st_nxt = ST_WPULSE;
               t_val  = CW'(WP_CYC - 1);
            end else begin
               st_nxt = ST_RDWAIT;
               t_val  = CW'(ACC_CYC - 1);
            end
         end
         ST_RDWAIT, ST_WPULSE: begin
            if (t_exp) begin
               st_nxt = ST_RECOVER;
               t_load = 1'b1;
               t_val  = CW'(REC_CYC - 1);
            end
         end
         ST_RECOVER: begin
            if (t_exp) st_nxt = ST_IDLE;
         end
         default: st_nxt = ST_IDLE;
      endcase
   end

   srac_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (t_load),
      .load_val (t_val),
      .expired  (t_exp)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q     <= ST_IDLE;
         mem_cs_n <= 1'b1;
         mem_we_n <= 1'b1;
         done     <= 1'b0;
         addr_q   <= '0;
         din_q    <= 1'b0;
         wr_q     <= 1'b0;
      end else begin
         st_q     <= st_nxt;
         mem_cs_n <= (st_nxt == ST_IDLE) || (st_nxt == ST_RECOVER);
         mem_we_n <= (st_nxt != ST_WPULSE);
         done     <= (st_q == ST_RECOVER) && t_exp;
         if (st_q == ST_IDLE && req) begin
            addr_q <= addr;
            din_q  <= wdata;
            wr_q   <= wr;
         end
      end
   end

   assign rd_cap = (st_q == ST_RDWAIT) && t_exp;

   srac_rd_latch u_rd (
      .clk (clk),
      .rst (rst),
      .cap (rd_cap),
      .d   (mem_dout),
      .q   (rdata)
   );

   assign ready    = (st_q == ST_IDLE);
   assign mem_addr = addr_q;
   assign mem_din  = din_q;

   // R8
   we_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
      !mem_we_n |-> !mem_cs_n);

   // R5
   addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!ready && !$past(ready)) |-> ($stable(mem_addr) && $stable(mem_din)));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // R2
   idle_strobes_chk: assert property (@(posedge clk) disable iff (rst)
      ready |-> (mem_cs_n && mem_we_n));

   // R4
   we_after_setup_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(mem_we_n) |-> ($past(!mem_cs_n) && $past(mem_we_n)));

endmodule

// File: tb/sim_sram_async_ctrl.sv
`timescale 1ns/1ps
module sim_sram_async_ctrl;

   localparam int CLK_PS = 8000;
   localparam int AW     = 20;
   localparam int C_ACC  = (20000 + CLK_PS - 1) / CLK_PS;
   localparam int C_WP1  = (15000 + CLK_PS - 1) / CLK_PS;
   localparam int C_WP2  = (17000 + CLK_PS - 1) / CLK_PS - 1;
   localparam int C_WP3  = (12000 + CLK_PS - 1) / CLK_PS - 1;
   localparam int E_ACC  = (C_ACC > 1) ? C_ACC : 1;
   localparam int E_WPa  = (C_WP1 > C_WP2) ? C_WP1 : C_WP2;
   localparam int E_WPb  = (E_WPa > C_WP3) ? E_WPa : C_WP3;
   localparam int E_WP   = (E_WPb > 1) ? E_WPb : 1;
   localparam int C_WR   = (2000 + CLK_PS - 1) / CLK_PS;
   localparam int C_RC   = (20000 + CLK_PS - 1) / CLK_PS;
   localparam int C_REM  = C_RC - 1 - ((E_ACC < E_WP) ? E_ACC : E_WP);
   localparam int E_RECa = (C_WR > 1) ? C_WR : 1;
   localparam int E_REC  = (E_RECa > C_REM) ? E_RECa : C_REM;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          req = 1'b0;
   logic          wr = 1'b0;
   logic          wdata = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          mem_dout = 1'b0;
   wire           ready, done, rdata, mem_cs_n, mem_we_n, mem_din;
   wire  [AW-1:0] mem_addr;

   int checks = 0;
   int fails  = 0;
   bit last_rd = 1'b0;
   bit mdl  [int];
   bit refm [int];

   always #4 clk = ~clk;

   sram_async_ctrl #(.ADDR_W(AW), .CLK_PS(CLK_PS)) u0 (
      .clk(clk), .rst(rst), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
      .ready(ready), .done(done), .rdata(rdata), .mem_addr(mem_addr),
      .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_din(mem_din),
      .mem_dout(mem_dout)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit mdl_rd(input logic [AW-1:0] a);
      return mdl.exists(int'(a)) ? mdl[int'(a)] : 1'b0;
   endfunction

   // behavioural memory: mode table, overlap rule, strobe-width and hold checks
   logic          p_cs = 1'b1, p_we = 1'b1, p_din = 1'b0;
   logic [AW-1:0] p_addr = '0;
   int            wlen = 0, rcnt = 0;
   always @(negedge clk) begin
      if (!rst) begin
         if (!mem_we_n && mem_cs_n) check(1'b0, "R8 we low without cs", 1, 0);
         if (!p_cs && !mem_cs_n && mem_addr != p_addr)
            check(1'b0, "R5 addr moved under cs", int'(mem_addr), int'(p_addr));
         if (!p_cs && !p_we && !mem_we_n && mem_din != p_din)
            check(1'b0, "R5 din moved under we", int'(mem_din), int'(p_din));
         if (!mem_cs_n && !mem_we_n) begin
            wlen++;
         end else if (!p_cs && !p_we) begin
            check(wlen == E_WP, "R4/R6 we pulse width", wlen, E_WP);
            mdl[int'(p_addr)] = p_din;
            wlen = 0;
         end
         if (!mem_cs_n && mem_we_n) rcnt++;
         else rcnt = 0;
         mem_dout <= (rcnt > E_ACC) ? mdl_rd(mem_addr) : ~mdl_rd(mem_addr);
      end
      p_cs   = mem_cs_n;
      p_we   = mem_we_n;
      p_addr = mem_addr;
      p_din  = mem_din;
   end

   task automatic txn(input bit w, input logic [AW-1:0] a, input bit d, input bit hold);
      int  ph;
      int  len;
      bit  e_cs, e_we;
      string st;
      ph  = w ? E_WP : E_ACC;
      len = 1 + ph + E_REC;
      st  = w ? "R4/R6" : "R3/R6";
      req = 1'b1; wr = w; addr = a; wdata = d;
      if (w) refm[int'(a)] = d;
      @(negedge clk);
      for (int j = 0; j <= len; j++) begin
         if (j > 0) @(negedge clk);
         e_cs = !(j <= ph);
         e_we = !(w && j >= 1 && j <= ph);
         check(mem_cs_n == e_cs, {st, " cs_n"}, int'(mem_cs_n), int'(e_cs));
         check(mem_we_n == e_we, {st, " we_n"}, int'(mem_we_n), int'(e_we));
         check(ready == (j == len), "R2 ready", int'(ready), int'(j == len));
         check(done == (j == len), "R7 done", int'(done), int'(j == len));
         if (j < len) begin
            check(mem_addr == a, "R5 addr held", int'(mem_addr), int'(a));
            if (w) check(mem_din == d, "R5 din held", int'(mem_din), int'(d));
         end
         if (j == 0) begin
            if (hold) begin addr = ~a; wr = ~w; wdata = ~d; end
            else req = 1'b0;
         end
         if (j == len - 1) req = 1'b0;
         if (j == len) begin
            if (!w) last_rd = refm.exists(int'(a)) ? refm[int'(a)] : 1'b0;
            check(rdata == last_rd, w ? "R7 rdata kept" : "R9 read value",
                  int'(rdata), int'(last_rd));
         end
      end
   endtask

   task automatic report();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "watchdog expired", 0, 1);
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      check(ready && mem_cs_n && mem_we_n && !done && !rdata, "R1 reset state",
            {ready, mem_cs_n, mem_we_n, done, rdata}, 5'b11100);
      rst = 1'b0;
      @(negedge clk);
      check(ready && mem_cs_n && mem_we_n && !done && !rdata, "R1 after release",
            {ready, mem_cs_n, mem_we_n, done, rdata}, 5'b11100);
      txn(1'b0, 20'd5, 1'b0, 1'b0);
      txn(1'b1, 20'd0, 1'b1, 1'b0);
      txn(1'b1, 20'hFFFFF, 1'b1, 1'b0);
      txn(1'b0, 20'd0, 1'b0, 1'b0);
      txn(1'b0, 20'hFFFFF, 1'b0, 1'b0);
      txn(1'b0, 20'd1, 1'b0, 1'b0);
      txn(1'b1, 20'hFFFFF, 1'b0, 1'b0);
      txn(1'b0, 20'hFFFFF, 1'b0, 1'b0);
      // R2: req held and inputs scrambled while busy
      txn(1'b1, 20'd7, 1'b1, 1'b1);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check(ready && mem_cs_n && mem_we_n, "R2 no restart after busy req",
               {ready, mem_cs_n, mem_we_n}, 3'b111);
      end
      txn(1'b0, 20'd7, 1'b0, 1'b1);
      for (int k = 0; k < 40; k++) begin
         automatic logic [AW-1:0] a = AW'($urandom % 32);
         if ($urandom % 2) a = a ^ 20'hFFFE0;
         txn(1'($urandom % 2), a, 1'($urandom % 2), 1'($urandom % 2));
      end
      @(negedge clk);
      report();
   end

endmodule